// File: doc/BRIEF.md
# Unaligned Quad-Word Load Aligner

This block lets a load fetch a full 128-bit quad word whose start address falls on any 16-bit boundary, rather than only on a quad boundary. It is placed between an aligned memory read port and a register-file write port. Each aligned quad that memory returns is pushed into a two-entry window. The previously newest entry becomes the older entry, and the fetched quad becomes the newest.

A load request carries the 16-bit-word offset of its start address within the quad. The block joins the upper lanes of the older entry with the lower lanes of the newer entry to form the requested quad. A request made before enough data is present is held until the fetches arrive. A flush drops the window and any held request, so that a new, non-sequential stream starts with a fresh priming fetch. A non-sequential stream takes two fetches before its first unaligned result. After that, each sequential load needs one fetch.

Top module: `qword_realign`

## Requirements
- R1: After reset, `out_valid_o` is 0, `out_data_o` is all zero, and the window is empty, so a zero-offset request with no fetch produces no output.
- R2: Lane i of any quad occupies bits [16i+15:16i], and lane 0 holds the lowest address. `ld_offs_i` (0 to 7) is the low three bits of the 16-bit-word start address.
- R3: For an offset k from 1 to 7, output lanes 0 to 7-k are older-entry lanes k to 7, and output lanes 8-k to 7 are newer-entry lanes 0 to k-1.
- R4: An offset of 0 bypasses the merge and returns the newest fetched quad unchanged.
- R5: Each cycle with `mem_valid_i` high moves the newest entry into the older slot and stores `mem_data_i` as the newest. The window never holds more than two entries.
- R6: A non-zero offset needs two entries and a zero offset needs one. A request that cannot yet be served is held. It produces its output in the cycle after the edge at which the condition is first met.
- R7: A fetch and a request in the same cycle are handled together: the request is served using the window that includes that fetch.
- R8: `flush_i` empties the window and cancels a held request. A fetch or a request in the same cycle as the flush belongs to the new stream.
- R9: A new request while one is held replaces the held offset.
- R10: `out_valid_o` is high for exactly one cycle per served request. `out_data_o` keeps its value while `out_valid_o` is low.
- R11: Serving a load does not consume window entries, so repeated requests without fetches return results from the same two entries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush_i | input | 1 | Starts a new stream: empties the window and drops the held request |
| ld_req_i | input | 1 | Load request strobe |
| ld_offs_i | input | 3 | 16-bit-word offset of the start address within its quad |
| mem_valid_i | input | 1 | Aligned memory data valid this cycle |
| mem_data_i | input | 128 | Aligned quad word from memory |
| out_valid_o | output | 1 | Realigned quad valid (one-cycle pulse) |
| out_data_o | output | 128 | Realigned quad word for the register file |

## Verification
The checks that run on every cycle cover four behaviours:
- A flush suppresses output, except for a same-cycle zero-offset bypass.
- A zero-offset request with a fetch returns that fetch on the next cycle.
- A request against a full window is served on the next cycle.
- Output pulses only follow a request, and the output data holds while it is not valid.

The lane arrangement for each offset, the priming sequence after a flush, the replacement of a held offset, and the reuse of the window by repeated loads depend on ordered stimulus. Only the bench's vector table and its offset sweep show these.

// File: rtl/qra_pkg.sv
// Shared types for the quad-word realigner.
// Assumes a window of at most two aligned entries.
package qra_pkg;
    typedef enum logic [1:0] {
        FILL_EMPTY = 2'd0,
        FILL_ONE   = 2'd1,
        FILL_TWO   = 2'd2
    } fill_e;
endpackage

// File: rtl/qra_window.sv
// Two-entry window of aligned quads fetched in sequence.
// Exposes next-state values so that a same-cycle fetch is visible to a load.
// Assumes fetches arrive in ascending address order within a stream.
module qra_window
    import qra_pkg::*;
#(
    parameter int QUAD_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              push_i,
    input  logic [QUAD_W-1:0] push_data_i,
    output logic [QUAD_W-1:0] nxt_older_o,
    output logic [QUAD_W-1:0] nxt_newer_o,
    output fill_e             nxt_fill_o,
    output fill_e             fill_o
);
    logic [QUAD_W-1:0] older_q, newer_q;
    fill_e             fill_q;
    fill_e             base_fill;

    // Next window contents after the flush and then the fetch of this cycle.
    always_comb begin
        base_fill = flush_i ? FILL_EMPTY : fill_q;
        if (push_i) begin
            nxt_older_o = newer_q;
            nxt_newer_o = push_data_i;
            nxt_fill_o  = (base_fill == FILL_EMPTY) ? FILL_ONE : FILL_TWO;
        end else begin
            nxt_older_o = older_q;
            nxt_newer_o = newer_q;
            nxt_fill_o  = base_fill;
        end
    end

    // Window storage and fill level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            older_q <= '0;
            newer_q <= '0;
            fill_q  <= FILL_EMPTY;
        end else begin
            older_q <= nxt_older_o;
            newer_q <= nxt_newer_o;
            fill_q  <= nxt_fill_o;
        end
    end

    assign fill_o = fill_q;
endmodule

// File: rtl/qra_lane_shift.sv
// Lane selector that builds a quad from a 16-lane pool formed by the older
// (low) and newer (high) entries, starting at lane offs.
// Offset zero passes the newer entry through.
// Assumes QUAD_W/LANE_W is a power of two.
module qra_lane_shift #(
    parameter int QUAD_W = 128,
    parameter int LANE_W = 16
) (
    input  logic [QUAD_W-1:0]                     older_i,
    input  logic [QUAD_W-1:0]                     newer_i,
    input  logic [$clog2(QUAD_W/LANE_W)-1:0]      offs_i,
    output logic [QUAD_W-1:0]                     merged_o
);
    localparam int LANES  = QUAD_W / LANE_W;
    localparam int OFFS_W = $clog2(LANES);
    localparam int IDX_W  = OFFS_W + 1;

    logic [LANE_W-1:0] pool [2*LANES];
    logic [QUAD_W-1:0] shifted;

    genvar j;
    generate
        for (j = 0; j < LANES; j++) begin : g_pool
            assign pool[j]         = older_i[j*LANE_W +: LANE_W];
            assign pool[j + LANES] = newer_i[j*LANE_W +: LANE_W];
        end
        for (j = 0; j < LANES; j++) begin : g_lane
            logic [IDX_W-1:0] idx;
            assign idx = IDX_W'(j) + {1'b0, offs_i};
            assign shifted[j*LANE_W +: LANE_W] = pool[idx];
        end
    endgenerate

    // Zero offset means an aligned load: the newest quad is the answer.
    always_comb begin
        merged_o = (offs_i == '0) ? newer_i : shifted;
    end
endmodule

// File: rtl/qra_ctrl.sv
// Load control: holds one outstanding request and fires it once the window
// has enough entries for its offset.
// Assumes nxt_fill_i already reflects any flush and fetch of the same cycle.
module qra_ctrl
    import qra_pkg::*;
#(
    parameter int OFFS_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              req_i,
    input  logic [OFFS_W-1:0] offs_i,
    input  fill_e             nxt_fill_i,
    output logic              fire_o,
    output logic [OFFS_W-1:0] fire_offs_o,
    output logic              pend_o
);
    logic              pend_q;
    logic [OFFS_W-1:0] pend_offs_q;
    logic              live;
    logic              enough;

    // Effective request this cycle and whether the window can serve it.
    always_comb begin
        live        = req_i | (pend_q & ~flush_i);
        fire_offs_o = req_i ? offs_i : pend_offs_q;
        enough      = (fire_offs_o == '0) ? (nxt_fill_i != FILL_EMPTY)
                                          : (nxt_fill_i == FILL_TWO);
        fire_o      = live & enough;
    end

    // Held request register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q      <= 1'b0;
            pend_offs_q <= '0;
        end else begin
            pend_q      <= live & ~fire_o;
            pend_offs_q <= fire_offs_o;
        end
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/qword_realign.sv
// Unaligned quad-word load aligner: stitches two consecutive aligned quads
// into one quad starting at any 16-bit lane, registered at the output.
// Assumes memory returns aligned quads of one stream in ascending order.
module qword_realign
    import qra_pkg::*;
#(
    parameter int QUAD_W = 128,
    parameter int LANE_W = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                flush_i,
    input  logic                                ld_req_i,
    input  logic [$clog2(QUAD_W/LANE_W)-1:0]    ld_offs_i,
    input  logic                                mem_valid_i,
    input  logic [QUAD_W-1:0]                   mem_data_i,
    output logic                                out_valid_o,
    output logic [QUAD_W-1:0]                   out_data_o
);
    localparam int LANES  = QUAD_W / LANE_W;
    localparam int OFFS_W = $clog2(LANES);

    logic [QUAD_W-1:0] nxt_older, nxt_newer, merged;
    fill_e             nxt_fill, fill_q;
    logic              fire, pend_q;
    logic [OFFS_W-1:0] fire_offs;

    qra_window #(.QUAD_W(QUAD_W)) u_window (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_i     (flush_i),
        .push_i      (mem_valid_i),
        .push_data_i (mem_data_i),
        .nxt_older_o (nxt_older),
        .nxt_newer_o (nxt_newer),
        .nxt_fill_o  (nxt_fill),
        .fill_o      (fill_q)
    );

    qra_ctrl #(.OFFS_W(OFFS_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_i     (flush_i),
        .req_i       (ld_req_i),
        .offs_i      (ld_offs_i),
        .nxt_fill_i  (nxt_fill),
        .fire_o      (fire),
        .fire_offs_o (fire_offs),
        .pend_o      (pend_q)
    );

    qra_lane_shift #(.QUAD_W(QUAD_W), .LANE_W(LANE_W)) u_shift (
        .older_i  (nxt_older),
        .newer_i  (nxt_newer),
        .offs_i   (fire_offs),
        .merged_o (merged)
    );

    // Output register: one pulse per served load, data held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_o <= 1'b0;
            out_data_o  <= '0;
        end else begin
            out_valid_o <= fire;
            if (fire) begin
                out_data_o <= merged;
            end
        end
    end
endmodule

// File: rtl/qra_checks.sv
// Cycle-level properties of the realigner, bound to its top module.
module qra_checks
    import qra_pkg::*;
#(
    parameter int QUAD_W = 128,
    parameter int LANE_W = 16
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             flush_i,
    input logic                             ld_req_i,
    input logic [$clog2(QUAD_W/LANE_W)-1:0] ld_offs_i,
    input logic                             mem_valid_i,
    input logic [QUAD_W-1:0]                mem_data_i,
    input logic                             out_valid_o,
    input logic [QUAD_W-1:0]                out_data_o,
    input logic                             pend_q,
    input fill_e                            fill_q
);
    // R8: a flush leaves at most one entry, so only a zero-offset bypass may fire.
    p_flush_no_stitch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i && !(mem_valid_i && ld_req_i && ld_offs_i == '0) |=> !out_valid_o);

    // R4: zero offset with a fetch returns that fetch unchanged.
    p_zero_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ld_req_i && ld_offs_i == '0 && mem_valid_i
        |=> out_valid_o && out_data_o == $past(mem_data_i));

    // R6: a full window serves any request on the next cycle.
    p_full_window_fires_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ld_req_i && !flush_i && fill_q == FILL_TWO |=> out_valid_o);

    // R10: a result pulse only follows a new or held request.
    p_valid_needs_request_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> $past(ld_req_i || pend_q));

    // R10: data holds while no result is presented.
    p_hold_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid_o |-> $stable(out_data_o));
endmodule

bind qword_realign qra_checks #(.QUAD_W(QUAD_W), .LANE_W(LANE_W)) u_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush_i     (flush_i),
    .ld_req_i    (ld_req_i),
    .ld_offs_i   (ld_offs_i),
    .mem_valid_i (mem_valid_i),
    .mem_data_i  (mem_data_i),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o),
    .pend_q      (pend_q),
    .fill_q      (fill_q)
);

// File: tb/qword_realign_test.sv
// Bench: vector table walked by one loop, then reset and offset-sweep tests.
module qword_realign_test;
    localparam int QW = 128;
    localparam int NV = 21;

    typedef struct packed {
        logic       flush;
        logic       fetch;
        logic [7:0] ftag;
        logic       req;
        logic [2:0] offs;
        logic       ev;
        logic [7:0] eold;
        logic [7:0] enew;
        logic [2:0] eoff;
    } vec_t;

    // flush fetch tag req offs | exp_valid old new offset
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b0,8'h00,1'b1,3'd0, 1'b0,8'h00,8'h00,3'd0}, // 0  R1 empty window
        '{1'b0,1'b1,8'h10,1'b0,3'd0, 1'b1,8'h00,8'h10,3'd0}, // 1  R6 held zero offset fires
        '{1'b0,1'b1,8'h11,1'b1,3'd3, 1'b1,8'h10,8'h11,3'd3}, // 2  R7 same-cycle fetch
        '{1'b0,1'b0,8'h00,1'b1,3'd5, 1'b1,8'h10,8'h11,3'd5}, // 3  R3
        '{1'b0,1'b0,8'h00,1'b1,3'd5, 1'b1,8'h10,8'h11,3'd5}, // 4  R11 reuse
        '{1'b0,1'b0,8'h00,1'b0,3'd0, 1'b0,8'h00,8'h00,3'd0}, // 5  R10 idle
        '{1'b0,1'b1,8'h12,1'b1,3'd7, 1'b1,8'h11,8'h12,3'd7}, // 6  R5 shift
        '{1'b1,1'b0,8'h00,1'b1,3'd2, 1'b0,8'h00,8'h00,3'd0}, // 7  R8 flush
        '{1'b0,1'b1,8'h20,1'b0,3'd0, 1'b0,8'h00,8'h00,3'd0}, // 8  R6 priming
        '{1'b0,1'b1,8'h21,1'b0,3'd0, 1'b1,8'h20,8'h21,3'd2}, // 9  R6 second fetch
        '{1'b0,1'b0,8'h00,1'b1,3'd1, 1'b1,8'h20,8'h21,3'd1}, // 10 R3
        '{1'b0,1'b0,8'h00,1'b1,3'd0, 1'b1,8'h00,8'h21,3'd0}, // 11 R4
        '{1'b1,1'b1,8'h30,1'b1,3'd4, 1'b0,8'h00,8'h00,3'd0}, // 12 R8 new stream
        '{1'b0,1'b0,8'h00,1'b1,3'd6, 1'b0,8'h00,8'h00,3'd0}, // 13 R9 replace
        '{1'b0,1'b1,8'h31,1'b0,3'd0, 1'b1,8'h30,8'h31,3'd6}, // 14 R9
        '{1'b1,1'b0,8'h00,1'b0,3'd0, 1'b0,8'h00,8'h00,3'd0}, // 15 R8
        '{1'b0,1'b0,8'h00,1'b1,3'd1, 1'b0,8'h00,8'h00,3'd0}, // 16 held on empty
        '{1'b1,1'b0,8'h00,1'b0,3'd0, 1'b0,8'h00,8'h00,3'd0}, // 17 R8 cancel
        '{1'b0,1'b1,8'h50,1'b0,3'd0, 1'b0,8'h00,8'h00,3'd0}, // 18 R8
        '{1'b0,1'b1,8'h51,1'b0,3'd0, 1'b0,8'h00,8'h00,3'd0}, // 19 R8 nothing held
        '{1'b0,1'b0,8'h00,1'b1,3'd3, 1'b1,8'h50,8'h51,3'd3}  // 20 R3
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          flush_i, ld_req_i, mem_valid_i;
    logic [2:0]    ld_offs_i;
    logic [QW-1:0] mem_data_i;
    logic          out_valid_o;
    logic [QW-1:0] out_data_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    qword_realign uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_i     (flush_i),
        .ld_req_i    (ld_req_i),
        .ld_offs_i   (ld_offs_i),
        .mem_valid_i (mem_valid_i),
        .mem_data_i  (mem_data_i),
        .out_valid_o (out_valid_o),
        .out_data_o  (out_data_o)
    );

    // R2: lane j of a tagged quad holds {tag, j}, lane 0 in bits [15:0].
    function automatic logic [QW-1:0] mk_quad(input logic [7:0] tag);
        logic [QW-1:0] q;
        for (int j = 0; j < 8; j++) q[j*16 +: 16] = {tag, 8'(j)};
        return q;
    endfunction

    // R3/R4: expected result from the older and newer tags and the offset.
    function automatic logic [QW-1:0] exp_quad(input logic [7:0] t_old,
                                               input logic [7:0] t_new,
                                               input int k);
        logic [QW-1:0] q;
        for (int i = 0; i < 8; i++) begin
            if (k == 0)         q[i*16 +: 16] = {t_new, 8'(i)};
            else if (i + k < 8) q[i*16 +: 16] = {t_old, 8'(i + k)};
            else                q[i*16 +: 16] = {t_new, 8'(i + k - 8)};
        end
        return q;
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [QW-1:0] act, input logic [QW-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic fl, input logic fe, input logic [7:0] tag,
                         input logic rq, input logic [2:0] k);
        @(negedge clk);
        flush_i     = fl;
        mem_valid_i = fe;
        mem_data_i  = fe ? mk_quad(tag) : '0;
        ld_req_i    = rq;
        ld_offs_i   = k;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(8 * 20000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [QW-1:0] last;
        rst_n = 1'b0; flush_i = 1'b0; ld_req_i = 1'b0; mem_valid_i = 1'b0;
        ld_offs_i = '0; mem_data_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(out_valid_o == 1'b0, "R1 valid", QW'(out_valid_o), '0);
        chk(out_data_o == '0, "R1 data", out_data_o, '0);
        last = out_data_o;

        for (int v = 0; v < NV; v++) begin
            drive(VEC[v].flush, VEC[v].fetch, VEC[v].ftag, VEC[v].req, VEC[v].offs);
            chk(out_valid_o == VEC[v].ev, $sformatf("R6/R8 valid vec %0d", v),
                QW'(out_valid_o), QW'(VEC[v].ev));
            if (VEC[v].ev)
                chk(out_data_o == exp_quad(VEC[v].eold, VEC[v].enew, int'(VEC[v].eoff)),
                    $sformatf("R3 data vec %0d", v), out_data_o,
                    exp_quad(VEC[v].eold, VEC[v].enew, int'(VEC[v].eoff)));
            else
                chk(out_data_o == last, $sformatf("R10 hold vec %0d", v), out_data_o, last);
            last = out_data_o;
        end

        // R1: reset mid-stream empties the window.
        @(negedge clk);
        rst_n = 1'b0; flush_i = 1'b0; ld_req_i = 1'b0; mem_valid_i = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b0, 1'b0, 8'h00, 1'b1, 3'd0);
        chk(out_valid_o == 1'b0, "R1 empty after reset", QW'(out_valid_o), '0);
        chk(out_data_o == '0, "R1 data after reset", out_data_o, '0);

        // R6: held zero-offset request served by the first fetch.
        drive(1'b0, 1'b1, 8'h70, 1'b0, 3'd0);
        chk(out_valid_o && out_data_o == mk_quad(8'h70), "R6 held bypass",
            out_data_o, mk_quad(8'h70));
        drive(1'b0, 1'b1, 8'h71, 1'b0, 3'd0);
        chk(out_valid_o == 1'b0, "R10 no request", QW'(out_valid_o), '0);

        // R2/R3/R4: sweep every offset over the same two entries.
        for (int k = 0; k < 8; k++) begin
            drive(1'b0, 1'b0, 8'h00, 1'b1, 3'(k));
            chk(out_valid_o == 1'b1, $sformatf("R2 valid offset %0d", k),
                QW'(out_valid_o), QW'(1));
            chk(out_data_o == exp_quad(8'h70, 8'h71, k),
                $sformatf("R2/R3 offset %0d", k), out_data_o, exp_quad(8'h70, 8'h71, k));
        end

        drive(1'b0, 1'b0, 8'h00, 1'b0, 3'd0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule